// File: doc/BRIEF.md
# SMBus Clock-Stretch Timeout Monitor

This block observes the clock and data lines of one SMBus/I2C port and measures how long the local device itself keeps the clock low. Time is counted in ticks of a prescaled timebase, and only while the local device reports that it is stretching and the synchronised clock is low. Several separate stretches are added together, so the block enforces a cumulative budget instead of timing a single long low phase.

Two budgets are kept. When the port acts as master, stretching is summed inside each byte segment: a segment starts at a START condition or at the end of an acknowledge clock, and ends at the next acknowledge clock or at STOP. When the port acts as slave, stretching is summed over a whole message, from START to STOP. Passing either budget raises a sticky flag for that mode and a shared low-timeout flag. In master mode the block also turns a slave-violation report from elsewhere into a one-cycle abort request. The request is timed to the next byte boundary, so the controller can issue a STOP after the byte in flight has finished.

Top module: `smbus_stretch_monitor`

## Requirements
- R1: After a synchronous active-low reset, `mext_flag`, `sext_flag`, `lowto_flag` and `abort_req` are all 0.
- R2: In master mode (`master_mode`=1), one tick is added whenever a prescaler tick occurs while `local_stretch`=1 and the synchronised SCL is low. Ticks from several stretches add up. `mext_flag` rises on the clock after the sum becomes strictly greater than `mext_limit`.
- R3: The master sum returns to zero at START (SDA falls while SCL is high), at STOP (SDA rises while SCL is high) and on the SCL falling edge after the ninth SCL rising edge since START or since the previous such boundary. Stretching in different byte segments is therefore never added together.
- R4: In slave mode (`master_mode`=0), stretching is summed in the same way from START to STOP with no reset at acknowledge clocks. `sext_flag` rises when the sum becomes strictly greater than `sext_limit`.
- R5: `lowto_flag` sets in the same cycle that either `mext_flag` or `sext_flag` sets.
- R6: Each flag stays at 1 until its own clear input (`clear_mext`, `clear_sext`, `clear_lowto`) is 1 at a clock edge. If a clear and a new trigger reach the same edge, the flag stays 1.
- R7: A limit value of 0 switches off that mode's comparison, so the matching flag never sets.
- R8: `abort_req` is a one-cycle pulse. It is raised at the first byte boundary (as in R3) after a cycle in which `slave_violation`=1, and only while in master mode. It is never raised in slave mode.
- R9: Only the accumulator of the selected mode counts. Stretching in slave mode never sets `mext_flag`, and stretching in master mode never sets `sext_flag`.
- R10: Stretch time is counted once every `PRESCALE` clock cycles, not on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| master_mode | input | 1 | 1 selects master measurement, 0 selects slave measurement |
| local_stretch | input | 1 | 1 while this device is holding SCL low |
| slave_violation | input | 1 | Report that the remote slave broke its timing rules |
| mext_limit | input | LIMIT_W | Per-byte master stretch budget in ticks, 0 turns it off |
| sext_limit | input | LIMIT_W | Per-message slave stretch budget in ticks, 0 turns it off |
| clear_mext | input | 1 | Write-one-to-clear for mext_flag |
| clear_sext | input | 1 | Write-one-to-clear for sext_flag |
| clear_lowto | input | 1 | Write-one-to-clear for lowto_flag |
| mext_flag | output | 1 | Sticky master budget exceeded |
| sext_flag | output | 1 | Sticky slave budget exceeded |
| lowto_flag | output | 1 | Sticky combined low-timeout indication |
| abort_req | output | 1 | One-cycle request to end the transfer with STOP |

## Verification
The accumulators, the bit counter and the pending-abort state cannot be seen directly, so a fault inside them shows up only through the flags and the abort pulse. A bit counter that slips by one moves the segment boundary. Stretches that belong to two different bytes are then added together, and a flag rises that should have stayed low. The abort pulse can also appear one SCL edge early or late. A wrong accumulator value or prescaler rate moves the rising edge of `mext_flag` or `sext_flag` by at least one tick, and this shows within one `PRESCALE` period after the budget is crossed. The bench therefore compares every output against a behavioural model on every clock, so a deviation is caught in the cycle it first reaches a port.

// File: rtl/smb_mon_pkg.sv
// Shared types for the SMBus clock-stretch timeout monitor.
// Assumes: a single clock domain for all consumers of these types.
package smb_mon_pkg;

    // Bus events decoded from the synchronised SCL/SDA lines
    typedef struct packed {
        logic start;     // SDA fell while SCL high
        logic stop;      // SDA rose while SCL high
        logic scl_rise;  // SCL went high
        logic scl_fall;  // SCL went low
        logic scl_low;   // SCL currently low
    } line_evt_t;

endpackage

// File: rtl/smb_line_sync.sv
// Synchronises SCL and SDA through a flop chain and decodes bus events.
// Assumes: SYNC_STAGES >= 2; both lines idle high, so chains reset to 1.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output smb_mon_pkg::line_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single-stage capture of both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_in;
                    sda_chain <= sda_in;
                end
            end
        end else begin : g_multi
            // Shift both lines through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
                    sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    // Keep the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode START, STOP and SCL edges from current and previous levels
    always_comb begin
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.scl_low  = ~scl_s;
    end

endmodule

// File: rtl/smb_frame_tracker.sv
// Tracks message state and SCL clocks to find byte and message boundaries.
// Assumes: START/STOP and SCL edge pulses are one cycle wide and never coincide
// with an SCL edge (both need SCL high on two samples).
module smb_frame_tracker #(
    parameter int BIT_CLOCKS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic scl_rise,
    input  logic scl_fall,
    output logic byte_bnd,
    output logic msg_bnd
);
    localparam int CNT_W = $clog2(BIT_CLOCKS + 1);

    logic             in_msg;
    logic             ack_seen;
    logic [CNT_W-1:0] bit_cnt;
    logic             ack_bnd;

    assign ack_bnd  = in_msg & ack_seen & scl_fall;
    assign byte_bnd = start | stop | ack_bnd;
    assign msg_bnd  = start | stop;

    // Count SCL clocks per byte and flag the acknowledge clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_msg   <= 1'b0;
            ack_seen <= 1'b0;
            bit_cnt  <= '0;
        end else if (start) begin
            in_msg   <= 1'b1;
            ack_seen <= 1'b0;
            bit_cnt  <= '0;
        end else if (stop) begin
            in_msg   <= 1'b0;
            ack_seen <= 1'b0;
            bit_cnt  <= '0;
        end else if (in_msg) begin
            if (scl_rise && bit_cnt < CNT_W'(BIT_CLOCKS)) begin
                bit_cnt  <= bit_cnt + 1'b1;
                ack_seen <= (bit_cnt == CNT_W'(BIT_CLOCKS - 1));
            end else if (ack_bnd) begin
                bit_cnt  <= '0;
                ack_seen <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/smb_stretch_accum.sv
// Saturating tick accumulator compared against a programmable limit.
// Assumes: clr has priority over inc; a limit of zero disables the compare.
module smb_stretch_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             inc,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             over
);
    logic [CNT_W-1:0] acc;
    logic             at_max;

    assign at_max = &acc;

    // Clear at a boundary, otherwise add one tick without wrapping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en && inc && !at_max) begin
            acc <= acc + 1'b1;
        end
    end

    // Exceeded when enabled, limit nonzero and sum strictly above it
    assign over = en & (|limit) & (acc > limit);

endmodule

// File: rtl/smbus_stretch_monitor.sv
// Top level: cumulative clock-stretch monitor for one SMBus/I2C port.
// Master mode sums local stretching per byte segment, slave mode per message.
// Assumes: local_stretch, master_mode, slave_violation and the limits are
// synchronous to clk; scl_in and sda_in may be asynchronous.
module smbus_stretch_monitor #(
    parameter int PRESCALE    = 4,
    parameter int LIMIT_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BIT_CLOCKS  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               master_mode,
    input  logic               local_stretch,
    input  logic               slave_violation,
    input  logic [LIMIT_W-1:0] mext_limit,
    input  logic [LIMIT_W-1:0] sext_limit,
    input  logic               clear_mext,
    input  logic               clear_sext,
    input  logic               clear_lowto,
    output logic               mext_flag,
    output logic               sext_flag,
    output logic               lowto_flag,
    output logic               abort_req
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    smb_mon_pkg::line_evt_t evt;
    logic tick;
    logic byte_bnd;
    logic msg_bnd;
    logic stretch_tick;
    logic m_over;
    logic s_over;
    logic abort_pend;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    smb_frame_tracker #(.BIT_CLOCKS(BIT_CLOCKS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (evt.start),
        .stop     (evt.stop),
        .scl_rise (evt.scl_rise),
        .scl_fall (evt.scl_fall),
        .byte_bnd (byte_bnd),
        .msg_bnd  (msg_bnd)
    );

    generate
        if (PRESCALE <= 1) begin : g_nopre
            assign tick = 1'b1;
        end else begin : g_pre
            logic [PRE_W-1:0] pre_cnt;
            // Free-running timebase divider
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (pre_cnt == PRE_W'(PRESCALE - 1)) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end
            assign tick = (pre_cnt == PRE_W'(PRESCALE - 1));
        end
    endgenerate

    assign stretch_tick = tick & local_stretch & evt.scl_low;

    smb_stretch_accum #(.CNT_W(LIMIT_W)) u_macc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (master_mode),
        .inc   (stretch_tick),
        .clr   (byte_bnd),
        .limit (mext_limit),
        .over  (m_over)
    );

    smb_stretch_accum #(.CNT_W(LIMIT_W)) u_sacc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (~master_mode),
        .inc   (stretch_tick),
        .clr   (msg_bnd),
        .limit (sext_limit),
        .over  (s_over)
    );

    // Sticky flags: a new trigger wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mext_flag  <= 1'b0;
            sext_flag  <= 1'b0;
            lowto_flag <= 1'b0;
        end else begin
            mext_flag  <= m_over | (mext_flag & ~clear_mext);
            sext_flag  <= s_over | (sext_flag & ~clear_sext);
            lowto_flag <= m_over | s_over | (lowto_flag & ~clear_lowto);
        end
    end

    // Hold a slave-violation report and pulse abort at the next byte boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_pend <= 1'b0;
            abort_req  <= 1'b0;
        end else begin
            abort_req  <= master_mode & abort_pend & byte_bnd;
            abort_pend <= master_mode & ((abort_pend & ~byte_bnd) | slave_violation);
        end
    end

endmodule

// File: rtl/smbus_stretch_monitor_chk.sv
// Property checker for smbus_stretch_monitor, attached with bind.
// Assumes: observes top-level ports only.
module smbus_stretch_monitor_chk #(
    parameter int LIMIT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               master_mode,
    input logic [LIMIT_W-1:0] mext_limit,
    input logic [LIMIT_W-1:0] sext_limit,
    input logic               clear_mext,
    input logic               clear_sext,
    input logic               clear_lowto,
    input logic               mext_flag,
    input logic               sext_flag,
    input logic               lowto_flag,
    input logic               abort_req
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mext_flag && !sext_flag && !lowto_flag && !abort_req));

    p_mext_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mext_flag && !clear_mext) |=> mext_flag);

    p_sext_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sext_flag && !clear_sext) |=> sext_flag);

    p_lowto_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lowto_flag && !clear_lowto) |=> lowto_flag);

    p_lowto_with_mext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mext_flag) |-> lowto_flag);

    p_lowto_with_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sext_flag) |-> lowto_flag);

    p_mext_limit_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mext_flag) |-> ($past(mext_limit) != '0));

    p_sext_limit_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sext_flag) |-> ($past(sext_limit) != '0));

    p_mext_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mext_flag) |-> $past(master_mode));

    p_sext_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sext_flag) |-> !$past(master_mode));

    p_abort_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    p_abort_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> $past(master_mode));

endmodule

bind smbus_stretch_monitor smbus_stretch_monitor_chk #(.LIMIT_W(LIMIT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .mext_limit  (mext_limit),
    .sext_limit  (sext_limit),
    .clear_mext  (clear_mext),
    .clear_sext  (clear_sext),
    .clear_lowto (clear_lowto),
    .mext_flag   (mext_flag),
    .sext_flag   (sext_flag),
    .lowto_flag  (lowto_flag),
    .abort_req   (abort_req)
);

// File: tb/tb_smbus_stretch_monitor.sv
module tb_smbus_stretch_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 2;
    localparam int LW         = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, master = 1'b1, stretch = 1'b0, viol = 1'b0;
    logic [LW-1:0] mlim = '0, slim = '0;
    logic clr_m = 1'b0, clr_s = 1'b0, clr_l = 1'b0;
    logic mext_flag, sext_flag, lowto_flag, abort_req;

    int checks = 0, errors = 0, cycles = 0, abort_cnt = 0;
    bit chk_en = 1'b0, done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_stretch_monitor #(.PRESCALE(PRE), .LIMIT_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .master_mode(master), .local_stretch(stretch), .slave_violation(viol),
        .mext_limit(mlim), .sext_limit(slim),
        .clear_mext(clr_m), .clear_sext(clr_s), .clear_lowto(clr_l),
        .mext_flag(mext_flag), .sext_flag(sext_flag),
        .lowto_flag(lowto_flag), .abort_req(abort_req)
    );

    // Behavioural reference model
    int  q_scl[$], q_sda[$];
    int  prev_scl, prev_sda, bits, pcnt, macc, sacc;
    bit  sess, ackp, pend;
    bit  e_m, e_s, e_l, e_a;

    initial begin
        q_scl = '{1, 1}; q_sda = '{1, 1};
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            q_scl = '{1, 1}; q_sda = '{1, 1};
            prev_scl = 1; prev_sda = 1; bits = 0; pcnt = 0; macc = 0; sacc = 0;
            sess = 0; ackp = 0; pend = 0; e_m = 0; e_s = 0; e_l = 0; e_a = 0;
        end else begin
            int cs, cd;
            bit st, sp, rise, fall, low, bb, mb, tk, mo, so;
            cs = q_scl[1]; cd = q_sda[1];
            st   = cs && prev_scl && prev_sda && !cd;
            sp   = cs && prev_scl && !prev_sda && cd;
            rise = cs && !prev_scl;
            fall = !cs && prev_scl;
            low  = !cs;
            bb = st || sp || (sess && ackp && fall);
            mb = st || sp;
            tk = (pcnt == PRE - 1);
            mo = master && mlim != 0 && macc > mlim;
            so = !master && slim != 0 && sacc > slim;
            e_m = mo || (e_m && !clr_m);
            e_s = so || (e_s && !clr_s);
            e_l = mo || so || (e_l && !clr_l);
            e_a = master && pend && bb;
            pend = master && ((pend && !bb) || viol);
            if (bb) macc = 0;
            else if (master && tk && stretch && low && macc < 65535) macc++;
            if (mb) sacc = 0;
            else if (!master && tk && stretch && low && sacc < 65535) sacc++;
            if (st) begin sess = 1; bits = 0; ackp = 0; end
            else if (sp) begin sess = 0; bits = 0; ackp = 0; end
            else if (sess) begin
                if (rise && bits < 9) begin ackp = (bits == 8); bits++; end
                else if (fall && ackp) begin ackp = 0; bits = 0; end
            end
            pcnt = tk ? 0 : pcnt + 1;
            prev_scl = cs; prev_sda = cd;
            q_scl.pop_back(); q_scl.push_front(int'(scl));
            q_sda.pop_back(); q_sda.push_front(int'(sda));
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (abort_req) abort_cnt++;
        if (chk_en) begin
            check("R2 mext_flag model", int'(mext_flag), int'(e_m));
            check("R4 sext_flag model", int'(sext_flag), int'(e_s));
            check("R5 lowto_flag model", int'(lowto_flag), int'(e_l));
            check("R8 abort_req model", int'(abort_req), int'(e_a));
        end
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1; sda = 1; wait_cyc(4);
        sda = 0; wait_cyc(4);
        scl = 0; wait_cyc(4);
    endtask

    task automatic bus_stop();
        sda = 0; wait_cyc(2);
        scl = 1; wait_cyc(4);
        sda = 1; wait_cyc(4);
    endtask

    task automatic bus_bit(int st_cyc, bit v);
        sda = v;
        if (st_cyc > 0) begin
            stretch = 1; wait_cyc(st_cyc); stretch = 0;
        end
        wait_cyc(1);
        scl = 1; wait_cyc(4);
        scl = 0; wait_cyc(2);
    endtask

    task automatic bus_byte(int s0, int s1);
        for (int i = 0; i < 9; i++)
            bus_bit(i == 0 ? s0 : (i == 1 ? s1 : 0), 1'b0);
    endtask

    task automatic clear_all();
        clr_m = 1; clr_s = 1; clr_l = 1; wait_cyc(1);
        clr_m = 0; clr_s = 0; clr_l = 0; wait_cyc(1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
        chk_en = 1;
        // R1: reset state
        check("R1 mext after reset", int'(mext_flag), 0);
        check("R1 sext after reset", int'(sext_flag), 0);
        check("R1 lowto after reset", int'(lowto_flag), 0);
        check("R1 abort after reset", int'(abort_req), 0);

        // R10 and R2: master, limit 6 ticks
        master = 1; mlim = 6; slim = 6;
        bus_start();
        bus_byte(10, 0);
        check("R10 10 cycles are 5 ticks", int'(mext_flag), 0);
        bus_byte(10, 6);
        check("R2 cumulative stretches exceed", int'(mext_flag), 1);
        check("R5 lowto with mext", int'(lowto_flag), 1);
        check("R9 no sext in master", int'(sext_flag), 0);
        bus_stop();
        clear_all();

        // R3: per-byte segments do not add
        bus_start();
        bus_byte(10, 0);
        bus_byte(10, 0);
        bus_stop();
        check("R3 segments separate", int'(mext_flag), 0);

        // R4 and R9: slave sums across bytes
        master = 0;
        bus_start();
        bus_byte(10, 0);
        check("R4 slave below limit", int'(sext_flag), 0);
        bus_byte(10, 0);
        check("R4 slave sum over message", int'(sext_flag), 1);
        check("R9 no mext in slave", int'(mext_flag), 0);
        check("R5 lowto with sext", int'(lowto_flag), 1);
        bus_stop();
        clear_all();
        check("R6 sext cleared", int'(sext_flag), 0);

        // R7: zero limit disables
        master = 1; mlim = 0;
        bus_start();
        bus_byte(30, 20);
        bus_stop();
        check("R7 zero limit no mext", int'(mext_flag), 0);
        check("R7 zero limit no lowto", int'(lowto_flag), 0);

        // R6: clear and trigger in the same cycle
        mlim = 3;
        bus_start();
        sda = 0; stretch = 1; wait_cyc(16);
        check("R6 set before clear", int'(mext_flag), 1);
        clr_m = 1; wait_cyc(1); clr_m = 0;
        check("R6 trigger beats clear", int'(mext_flag), 1);
        stretch = 0; wait_cyc(1);
        scl = 1; wait_cyc(4); scl = 0; wait_cyc(2);
        for (int i = 0; i < 8; i++) bus_bit(0, 1'b0);
        bus_stop();
        clr_m = 1; wait_cyc(1); clr_m = 0; wait_cyc(1);
        check("R6 mext cleared", int'(mext_flag), 0);
        check("R6 lowto kept", int'(lowto_flag), 1);
        clr_l = 1; wait_cyc(1); clr_l = 0; wait_cyc(1);
        check("R6 lowto cleared", int'(lowto_flag), 0);

        // R8: abort in master at next byte boundary
        mlim = 0;
        bus_start();
        abort_cnt = 0;
        bus_bit(0, 1'b0);
        viol = 1; wait_cyc(1); viol = 0;
        for (int i = 0; i < 7; i++) bus_bit(0, 1'b0);
        check("R8 no abort before ack", abort_cnt, 0);
        bus_bit(0, 1'b0);
        wait_cyc(2);
        check("R8 one abort after byte", abort_cnt, 1);
        bus_stop();

        // R8: no abort in slave mode
        master = 0;
        bus_start();
        abort_cnt = 0;
        viol = 1; wait_cyc(1); viol = 0;
        bus_byte(0, 0);
        bus_stop();
        check("R8 no abort in slave", abort_cnt, 0);

        wait_cyc(4);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule